// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block watches a multiplexed address/data bus and turns the address of each bus cycle into a group of active-low peripheral select lines. Software programs a base page. Select line n then covers the 256-byte window that begins n pages above that base. The address is taken from the bus while the address strobe is high, so a select is valid from the address phase onward. It stays valid after the strobe drops, until the next address phase replaces the captured address.

A mode bit picks whether the selects answer memory cycles or I/O cycles. The block compares this bit with the cycle-type input that is captured with the address. A second mode bit controls a dedicated output that carries the captured address bit 2. While that bit is clear, the output is driven with the latched bit. While it is set, the output is released so that the pin can serve another purpose. While another master holds the bus, nothing new is captured. The latched bit keeps its value and every select is deasserted.

Top module: `perisel_decoder`

## Requirements
- R1: While reset is asserted, every `pcs_n` bit is 1, `a2_oe` is 1 and `a2_out` is 0. The base page, the mode bits and the captured address are all cleared.
- R2: Until the base register has been written once after reset, every `pcs_n` bit stays 1, whatever the bus cycle and whatever is written to the mode register.
- R3: A write with `cfg_sel`=0 loads `cfg_wdata[11:0]` as the base page, which is compared with address bits 19:8. Bit n of `pcs_n` is 0 when the captured address page equals base + n, for n from 0 to 6. The result appears in the cycle after the clock edge that captures the address or writes the base.
- R4: A captured page below the base, or at base + 7 or above, leaves all `pcs_n` bits at 1. At most one `pcs_n` bit is 0 at any time. The sum base + n does not wrap past the top of the address space.
- R5: The address and cycle type are captured at each clock edge where `ale` is 1 and `hlda` is 0. While `ale` is 0 they hold, so the selects keep their value until the next address phase.
- R6: Mode bit 0 (`cfg_wdata[0]` of a write with `cfg_sel`=1) selects the decoded space: 0 matches memory cycles (`cyc_io`=0), 1 matches I/O cycles (`cyc_io`=1). A cycle of the other type asserts no select.
- R7: While mode bit 1 is 0, `a2_oe` is 1 and `a2_out` equals bit 2 of the most recently captured address.
- R8: While `hlda` is 1, every `pcs_n` bit is 1, no address is captured even if `ale` is 1, and `a2_out` keeps its value. When `hlda` returns to 0, the selects again decode the address captured before the hold.
- R9: While mode bit 1 is 1, `a2_oe` is 0 and `a2_out` is 0.
- R10: A write with `cfg_sel`=1 changes only the mode bits and leaves the base page and its written state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe, high during the address phase |
| ad_bus | input | 20 | Multiplexed address/data bus |
| cyc_io | input | 1 | Cycle type: 1 for I/O, 0 for memory |
| hlda | input | 1 | Bus hold acknowledge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Configuration target: 0 for base page, 1 for mode bits |
| cfg_wdata | input | 16 | Configuration write data |
| pcs_n | output | 7 | Active-low peripheral selects |
| a2_out | output | 1 | Latched address bit 2 |
| a2_oe | output | 1 | Drive enable for `a2_out` |

## Verification
The assertions assume that `ale`, `hlda`, `cyc_io` and the configuration port are synchronous to the clock, and that any level seen at an edge counts as that cycle's value. They also assume that a base page plus 6 is formed without wrapping, which the widened compare provides for every base value. The stimulus changes all inputs only at the falling clock edge and raises `ale` for a single cycle per bus cycle. It drives fresh data onto the bus while the strobe is low, so that the hold of the captured address is really tested. Hold is entered with `ale` high, so that the freeze of the capture path is exercised.

// File: rtl/perisel_pkg.sv
package perisel_pkg;

    // Mode register field positions (decoded by the cfg block and the bench)
    localparam int MODE_IO_BIT = 0;
    localparam int MODE_EX_BIT = 1;

    typedef enum logic {
        CFG_BASE = 1'b0,
        CFG_MODE = 1'b1
    } cfg_target_e;

    typedef struct packed {
        logic ex;        // 1: address-bit output released
        logic io_space;  // 1: decode I/O cycles
    } mode_t;

endpackage

// File: rtl/perisel_cfg_regs.sv
module perisel_cfg_regs
    import perisel_pkg::*;
#(
    parameter int PAGE_W = 12,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [PAGE_W-1:0] base_page,
    output mode_t             mode,
    output logic              base_valid
);

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        mode_t             mode;
        logic              valid;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_target_e'(cfg_sel) == CFG_BASE) begin
                cfg_d.base  = cfg_wdata[PAGE_W-1:0];
                cfg_d.valid = 1'b1;
            end else begin
                cfg_d.mode.io_space = cfg_wdata[MODE_IO_BIT];
                cfg_d.mode.ex       = cfg_wdata[MODE_EX_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_page  = cfg_q.base;
    assign mode       = cfg_q.mode;
    assign base_valid = cfg_q.valid;

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        base_valid |=> base_valid); // R2

    AST_MODE_WRITE_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> $stable(base_page) && $stable(base_valid)); // R10

endmodule

// File: rtl/perisel_addr_latch.sv
module perisel_addr_latch #(
    parameter int ADDR_W = 20,
    parameter int A2_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              hlda,
    input  logic [ADDR_W-1:0] ad_bus,
    input  logic              cyc_io,
    output logic [ADDR_W-1:0] addr_q,
    output logic              io_q,
    output logic              a2_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              io;
    } lat_state_t;

    lat_state_t lat_d, lat_q;
    logic       capture;

    assign capture = ale & ~hlda;

    always_comb begin
        lat_d = lat_q;
        if (capture) begin
            lat_d.addr = ad_bus;
            lat_d.io   = cyc_io;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign addr_q = lat_q.addr;
    assign io_q   = lat_q.io;
    assign a2_q   = lat_q.addr[A2_BIT];

    AST_ADDR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !hlda) |=> (addr_q == $past(ad_bus)) && (io_q == $past(cyc_io))); // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_q) && $stable(io_q)); // R5

    AST_A2_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |=> $stable(a2_q) && $stable(addr_q)); // R8

endmodule

// File: rtl/perisel_window_match.sv
module perisel_window_match #(
    parameter int PAGE_W  = 12,
    parameter int NUM_SEL = 7
) (
    input  logic [PAGE_W-1:0]  page,
    input  logic [PAGE_W-1:0]  base_page,
    input  logic               base_valid,
    input  logic               io_space,
    input  logic               cyc_io_q,
    input  logic               hold,
    output logic [NUM_SEL-1:0] hit
);

    localparam int CMP_W = PAGE_W + 1;

    logic enable;

    assign enable = base_valid & ~hold & (io_space == cyc_io_q);

    for (genvar n = 0; n < NUM_SEL; n++) begin : g_win
        logic [CMP_W-1:0] target;
        assign target = {1'b0, base_page} + CMP_W'(n);
        assign hit[n] = enable && ({1'b0, page} == target);
    end

endmodule

// File: rtl/perisel_decoder.sv
module perisel_decoder
    import perisel_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int WIN_BITS = 8,
    parameter int NUM_SEL  = 7,
    parameter int CFG_W    = 16,
    parameter int A2_BIT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ale,
    input  logic [ADDR_W-1:0]  ad_bus,
    input  logic               cyc_io,
    input  logic               hlda,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [NUM_SEL-1:0] pcs_n,
    output logic               a2_out,
    output logic               a2_oe
);

    localparam int PAGE_W = ADDR_W - WIN_BITS;

    logic [PAGE_W-1:0]  base_page;
    mode_t              mode;
    logic               base_valid;
    logic [ADDR_W-1:0]  addr_q;
    logic               io_q;
    logic               a2_q;
    logic [NUM_SEL-1:0] hit;

    perisel_cfg_regs #(
        .PAGE_W (PAGE_W),
        .CFG_W  (CFG_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .base_page  (base_page),
        .mode       (mode),
        .base_valid (base_valid)
    );

    perisel_addr_latch #(
        .ADDR_W (ADDR_W),
        .A2_BIT (A2_BIT)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale    (ale),
        .hlda   (hlda),
        .ad_bus (ad_bus),
        .cyc_io (cyc_io),
        .addr_q (addr_q),
        .io_q   (io_q),
        .a2_q   (a2_q)
    );

    perisel_window_match #(
        .PAGE_W  (PAGE_W),
        .NUM_SEL (NUM_SEL)
    ) u_match (
        .page       (addr_q[ADDR_W-1:WIN_BITS]),
        .base_page  (base_page),
        .base_valid (base_valid),
        .io_space   (mode.io_space),
        .cyc_io_q   (io_q),
        .hold       (hlda),
        .hit        (hit)
    );

    assign pcs_n  = ~hit;
    assign a2_oe  = ~mode.ex;
    assign a2_out = a2_q & ~mode.ex;

    AST_IDLE_UNTIL_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !base_valid |-> &pcs_n); // R2

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n)); // R4

    AST_HOLD_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> &pcs_n); // R8

    AST_EX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        mode.ex |-> (!a2_oe && !a2_out)); // R9

    AST_A2_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.ex |-> (a2_oe && (a2_out == addr_q[A2_BIT]))); // R7

endmodule

// File: tb/perisel_decoder_bench.sv
module perisel_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [19:0] ad_bus = '0;
    logic        cyc_io = 1'b0;
    logic        hlda = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [6:0]  pcs_n;
    logic        a2_out;
    logic        a2_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    perisel_decoder u_perisel_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .ad_bus    (ad_bus),
        .cyc_io    (cyc_io),
        .hlda      (hlda),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pcs_n     (pcs_n),
        .a2_out    (a2_out),
        .a2_oe     (a2_oe)
    );

    typedef struct packed {
        logic [11:0] base;
        logic [1:0]  mode;
        logic [19:0] addr;
        logic        io;
        logic [6:0]  exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{base: 12'h010, mode: 2'b00, addr: 20'h01000, io: 1'b0, exp: 7'b1111110},
        '{base: 12'h010, mode: 2'b00, addr: 20'h016FF, io: 1'b0, exp: 7'b0111111},
        '{base: 12'h010, mode: 2'b00, addr: 20'h01700, io: 1'b0, exp: 7'b1111111},
        '{base: 12'h010, mode: 2'b00, addr: 20'h00FFF, io: 1'b0, exp: 7'b1111111},
        '{base: 12'h010, mode: 2'b00, addr: 20'h012A4, io: 1'b1, exp: 7'b1111111},
        '{base: 12'h0F0, mode: 2'b01, addr: 20'h0F310, io: 1'b1, exp: 7'b1110111},
        '{base: 12'h0F0, mode: 2'b01, addr: 20'h0F310, io: 1'b0, exp: 7'b1111111},
        '{base: 12'hFFA, mode: 2'b00, addr: 20'hFFFFF, io: 1'b0, exp: 7'b1011111}
    };

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = 16'hDEAD;
    endtask

    task automatic bus_cycle(input logic [19:0] addr, input logic io);
        ale    = 1'b1;
        ad_bus = addr;
        cyc_io = io;
        @(negedge clk);
        ale    = 1'b0;
        ad_bus = ~addr;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pcs_n in reset", pcs_n, 7'h7F);
        check("R1 a2_oe in reset", {6'b0, a2_oe}, 7'd1);
        check("R1 a2_out in reset", {6'b0, a2_out}, 7'd0);
        rst_n = 1'b1;
        @(negedge clk);

        bus_cycle(20'h00000, 1'b0);
        check("R2 no select before base write", pcs_n, 7'h7F);
        cfg_write(1'b1, 16'h0000);
        check("R2 R10 mode write does not arm selects", pcs_n, 7'h7F);
        cfg_write(1'b0, 16'h0000);
        check("R3 R5 base write decodes held address", pcs_n, 7'b1111110);
        check("R7 a2 driven low", {5'b0, a2_oe, a2_out}, 7'b0000010);

        for (int i = 0; i < NVEC; i++) begin
            cfg_write(1'b0, {4'b0, VEC[i].base});
            cfg_write(1'b1, {14'b0, VEC[i].mode});
            bus_cycle(VEC[i].addr, VEC[i].io);
            check($sformatf("R3 R4 R6 vector %0d", i), pcs_n, VEC[i].exp);
            @(negedge clk);
            check($sformatf("R5 vector %0d held after strobe", i), pcs_n, VEC[i].exp);
        end

        check("R7 a2 follows bit 2 high", {5'b0, a2_oe, a2_out}, 7'b0000011);

        hlda   = 1'b1;
        ale    = 1'b1;
        ad_bus = 20'h00000;
        @(negedge clk);
        check("R8 selects off in hold", pcs_n, 7'h7F);
        check("R8 a2 frozen in hold", {6'b0, a2_out}, 7'd1);
        ale  = 1'b0;
        hlda = 1'b0;
        @(negedge clk);
        check("R8 no capture during hold", pcs_n, 7'b1011111);

        bus_cycle(20'hFFFFB, 1'b0);
        check("R7 a2 follows bit 2 low", {6'b0, a2_out}, 7'd0);
        bus_cycle(20'hFFFFF, 1'b0);
        check("R7 a2 back high", {6'b0, a2_out}, 7'd1);

        cfg_write(1'b1, 16'h0002);
        check("R9 output released", {5'b0, a2_oe, a2_out}, 7'b0000000);
        check("R10 mode write keeps base", pcs_n, 7'b1011111);
        bus_cycle(20'hFFFFC, 1'b0);
        check("R9 stays released on new cycle", {5'b0, a2_oe, a2_out}, 7'b0000000);

        cfg_write(1'b1, 16'h0001);
        check("R6 I/O space ignores memory cycle", pcs_n, 7'h7F);
        check("R7 drive back after clearing mode bit 1", {5'b0, a2_oe, a2_out}, 7'b0000011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule